// File: doc/BRIEF.md
# Pseudo-Random and Ramp Pattern Lock Monitor

This block checks a stream of converter sample words against a reference sequence it generates itself. The reference is one of four standard pseudo-random binary sequences or one of two counting ramps. It reports whether the stream is following that sequence. The block holds two sticky status flags. One is an out-of-sync flag. The other is an error flag that catches isolated bit errors once the monitor has locked.

While it is out of sync, the monitor predicts each word from the words it has just received, so it can relock on a live stream from any starting point. Once locked, it predicts each word from its own previous predictions. A single corrupted word then counts as exactly one mismatch. Losing sync needs a long run of misses, while regaining it needs a shorter run of hits. This hysteresis stops a noisy link from toggling the lock state.

The sample input uses valid/ready. Ready is always high, so the monitor never applies back-pressure. A word is consumed in every cycle where valid is high. The pattern select and the clear strobes are plain level inputs, sampled on each clock.

Top module: `pn_stream_monitor`

## Requirements
- R1: After reset, oos_flag reads 1, err_flag reads 0, and the live lock state is out of sync.
- R2: smp_ready is 1 in every cycle, including during reset. A word is consumed on each rising clock edge where smp_valid is 1.
- R3: From out of sync, the live state becomes in sync on the 16th consecutive word that matches its prediction, and not before. While out of sync, each word is predicted from the previously received words. For the word ramp (select 0xB), the prediction is the previous word plus 1 modulo 2^W, and the history is zero after reset.
- R4: While in sync, the live state goes out of sync on the 64th consecutive mismatching word, and not before. While in sync, each prediction follows on from the previous prediction, not from the received word.
- R5: A mismatching word while in sync sets err_flag, which stays set until a cycle with err_clr at 1. A new mismatch in that same cycle keeps it set.
- R6: err_flag is 0 in every cycle where the live state is out of sync, and mismatches while out of sync never set it.
- R7: Any matching word resets the miss run to zero, and any mismatching word resets the hit run to zero.
- R8: A change of pat_sel between two clock edges forces the live state out of sync at the edge that sees the change.
- R9: Select codes other than 0x4, 0x5, 0x6, 0x7, 0xA and 0xB keep the live state out of sync, whatever data arrives.
- R10: Each supported select locks onto a conforming stream and reports no errors. The selects are: 0x4 for x^7+x^6+1, 0x5 for x^15+x^14+1, 0x6 for x^23+x^18+1, 0x7 for x^31+x^28+1, 0xA for the nibble ramp and 0xB for the word ramp. For the polynomials, the bit stream runs most significant bit first, W bits per word. For the nibble ramp, every 4-bit group of the word holds the same count, which rises by 1 modulo 16 per word.
- R11: oos_flag is sticky. It is set in every cycle where the live state is out of sync, and it clears only in a cycle with oos_clr at 1 while the live state is in sync. With oos_clr held at 1, the flag therefore tracks the live state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample word valid |
| smp_ready | output | 1 | Always 1; no back-pressure |
| smp_data | input | W (16) | Sample word |
| pat_sel | input | 4 | Reference pattern select |
| oos_clr | input | 1 | Write-one-to-clear strobe for oos_flag |
| err_clr | input | 1 | Write-one-to-clear strobe for err_flag |
| oos_flag | output | 1 | Sticky out-of-sync status |
| err_flag | output | 1 | Sticky error status |

## Verification
Every supported select is swept with a stream built by the bench, using the recurrence or the counting rule for that select. A wrong tap or a wrong bit order would then never lock. The word ramp is used to count the exact lock and drop thresholds. It is also used to break a hit run with one glitch, which the self-seeding turns into two misses, and to break a miss run with a single good word. This separates the counter resets from a simple saturating count. Unsupported codes, a select change during a locked stream, and the clear strobes given in and out of sync show the forced state and the sticky behaviour.

// File: rtl/pnmon_pkg.sv
package pnmon_pkg;
  typedef enum logic [3:0] {
    SEL_PN7       = 4'h4,
    SEL_PN15      = 4'h5,
    SEL_PN23      = 4'h6,
    SEL_PN31      = 4'h7,
    SEL_RAMP_NIB  = 4'hA,
    SEL_RAMP_WORD = 4'hB
  } pat_sel_e;

  localparam int NUM_PN = 4;

  // highest exponent of each generator polynomial
  function automatic int pn_order(input int idx);
    case (idx)
      0: return 7;
      1: return 15;
      2: return 23;
      default: return 31;
    endcase
  endfunction

  // middle exponent of each polynomial
  function automatic int pn_tap(input int idx);
    case (idx)
      0: return 6;
      1: return 14;
      2: return 18;
      default: return 28;
    endcase
  endfunction

  function automatic logic [3:0] pn_code(input int idx);
    return 4'(4 + idx);
  endfunction
endpackage

// File: rtl/pnmon_refgen.sv
module pnmon_refgen
  import pnmon_pkg::*;
#(
  parameter int W    = 16,
  parameter int HIST = 48
) (
  input  logic [HIST-1:0] hist,
  input  logic [3:0]      sel,
  output logic [W-1:0]    exp_word,
  output logic            sel_ok
);
  localparam int NIBS = W / 4;

  logic [NUM_PN*W-1:0] pn_flat;
  logic [3:0]          nib_next;
  logic [W-1:0]        nib_word;
  logic [W-1:0]        ramp_word;

  // one unrolled serial recurrence per polynomial; newest bit at index 0
  generate
    for (genvar p = 0; p < NUM_PN; p++) begin : g_pn
      localparam int ORD = pn_order(p);
      localparam int TAP = pn_tap(p);
      logic [W-1:0] word;
      always_comb begin
        logic [HIST-1:0] r;
        logic            fb;
        r    = hist;
        word = '0;
        for (int i = 0; i < W; i++) begin
          fb          = r[ORD-1] ^ r[TAP-1];
          r           = {r[HIST-2:0], fb};
          word[W-1-i] = fb;
        end
      end
      assign pn_flat[p*W +: W] = word;
    end
  endgenerate

  assign nib_next  = hist[3:0] + 4'd1;
  assign nib_word  = {NIBS{nib_next}};
  assign ramp_word = hist[W-1:0] + W'(1);

  always_comb begin
    exp_word = '0;
    sel_ok   = 1'b0;
    for (int p = 0; p < NUM_PN; p++) begin
      if (sel == pn_code(p)) begin
        exp_word = pn_flat[p*W +: W];
        sel_ok   = 1'b1;
      end
    end
    if (sel == SEL_RAMP_NIB) begin
      exp_word = nib_word;
      sel_ok   = 1'b1;
    end
    if (sel == SEL_RAMP_WORD) begin
      exp_word = ramp_word;
      sel_ok   = 1'b1;
    end
  end
endmodule

// File: rtl/pnmon_lock.sv
module pnmon_lock #(
  parameter int LOCK_HITS   = 16,
  parameter int DROP_MISSES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic match,
  input  logic sel_ok,
  input  logic sel_chg,
  output logic oos_q,
  output logic oos_nxt
);
  localparam int HCW = $clog2(LOCK_HITS + 1);
  localparam int MCW = $clog2(DROP_MISSES + 1);
  localparam logic [HCW-1:0] HIT_MAX   = HCW'(LOCK_HITS);
  localparam logic [HCW-1:0] HIT_LAST  = HCW'(LOCK_HITS - 1);
  localparam logic [MCW-1:0] MISS_MAX  = MCW'(DROP_MISSES);
  localparam logic [MCW-1:0] MISS_LAST = MCW'(DROP_MISSES - 1);

  logic [HCW-1:0] hit_q, hit_n;
  logic [MCW-1:0] miss_q, miss_n;

  always_comb begin
    hit_n   = hit_q;
    miss_n  = miss_q;
    oos_nxt = oos_q;
    if (!sel_ok || sel_chg) begin
      oos_nxt = 1'b1;
      hit_n   = '0;
      miss_n  = '0;
    end else if (valid) begin
      if (match) begin
        miss_n = '0;
        if (hit_q != HIT_MAX) hit_n = hit_q + HCW'(1);
        if (oos_q && hit_q == HIT_LAST) oos_nxt = 1'b0;
      end else begin
        hit_n = '0;
        if (miss_q != MISS_MAX) miss_n = miss_q + MCW'(1);
        if (!oos_q && miss_q == MISS_LAST) oos_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oos_q  <= 1'b1;
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      oos_q  <= oos_nxt;
      hit_q  <= hit_n;
      miss_q <= miss_n;
    end
  end
endmodule

// File: rtl/pnmon_sticky.sv
module pnmon_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic oos_nxt,
  input  logic err_set,
  input  logic oos_clr,
  input  logic err_clr,
  output logic oos_flag,
  output logic err_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oos_flag <= 1'b1;
      err_flag <= 1'b0;
    end else begin
      oos_flag <= oos_nxt | (oos_flag & ~oos_clr);
      err_flag <= oos_nxt ? 1'b0 : (err_set | (err_flag & ~err_clr));
    end
  end
endmodule

// File: rtl/pn_stream_monitor.sv
module pn_stream_monitor #(
  parameter int W           = 16,
  parameter int LOCK_HITS   = 16,
  parameter int DROP_MISSES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  input  logic [3:0]   pat_sel,
  input  logic         oos_clr,
  input  logic         err_clr,
  output logic         oos_flag,
  output logic         err_flag
);
  localparam int HIST = W + 32;

  logic [HIST-1:0] hist_q;
  logic [3:0]      sel_q;
  logic [W-1:0]    exp_word;
  logic            sel_ok;
  logic            sel_chg;
  logic            accept;
  logic            match;
  logic            oos_q;
  logic            oos_nxt;
  logic            err_set;

  assign smp_ready = 1'b1;
  assign accept    = smp_valid & smp_ready;
  assign sel_chg   = (pat_sel != sel_q);
  assign match     = (smp_data == exp_word);
  assign err_set   = accept & sel_ok & ~sel_chg & ~oos_q & ~match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= pat_sel;
      hist_q <= '0;
    end else begin
      sel_q <= pat_sel;
      if (accept) hist_q <= {hist_q[HIST-W-1:0], (oos_q ? smp_data : exp_word)};
    end
  end

  pnmon_refgen #(.W(W), .HIST(HIST)) u_refgen (
    .hist     (hist_q),
    .sel      (pat_sel),
    .exp_word (exp_word),
    .sel_ok   (sel_ok)
  );

  pnmon_lock #(.LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (accept),
    .match   (match),
    .sel_ok  (sel_ok),
    .sel_chg (sel_chg),
    .oos_q   (oos_q),
    .oos_nxt (oos_nxt)
  );

  pnmon_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .oos_nxt  (oos_nxt),
    .err_set  (err_set),
    .oos_clr  (oos_clr),
    .err_clr  (err_clr),
    .oos_flag (oos_flag),
    .err_flag (err_flag)
  );
endmodule

// File: rtl/pnmon_checker.sv
module pnmon_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_valid,
  input logic [3:0] pat_sel,
  input logic       oos_live,
  input logic       oos_flag,
  input logic       err_flag
);
  logic code_known;
  assign code_known = (pat_sel == 4'h4) || (pat_sel == 4'h5) || (pat_sel == 4'h6) ||
                      (pat_sel == 4'h7) || (pat_sel == 4'hA) || (pat_sel == 4'hB);

  AST_ERR_QUIET_OOS: assert property (@(posedge clk) disable iff (!rst_n)
    oos_live |-> !err_flag); // R6

  AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    oos_live |-> oos_flag); // R11

  AST_SEL_CHANGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel != $past(pat_sel)) |=> oos_live); // R8

  AST_UNKNOWN_CODE_OOS: assert property (@(posedge clk) disable iff (!rst_n)
    !code_known |=> oos_live); // R9

  AST_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos_live) |-> $past(smp_valid)); // R3

  AST_ERR_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(smp_valid)); // R5
endmodule

bind pn_stream_monitor pnmon_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .pat_sel   (pat_sel),
  .oos_live  (oos_q),
  .oos_flag  (oos_flag),
  .err_flag  (err_flag)
);

// File: tb/pn_stream_monitor_tb_top.sv
`timescale 1ns/1ps
module pn_stream_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic        smp_ready;
  logic [15:0] smp_data;
  logic [3:0]  pat_sel;
  logic        oos_clr;
  logic        err_clr;
  logic        oos_flag;
  logic        err_flag;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] pn_sh;

  always #2 clk = ~clk;

  pn_stream_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .pat_sel(pat_sel), .oos_clr(oos_clr), .err_clr(err_clr),
    .oos_flag(oos_flag), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = w;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
  endtask

  // serial recurrence new = s[-ord] ^ s[-tap], most significant bit first
  task automatic pn_word(input int ord, input int tap, output logic [15:0] w);
    logic fb;
    for (int i = 0; i < 16; i++) begin
      fb = pn_sh[ord-1] ^ pn_sh[tap-1];
      pn_sh = {pn_sh[62:0], fb};
      w[15-i] = fb;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    logic [3:0]  nb;
    logic [3:0]  codes [6];
    logic [3:0]  bad_codes [4];
    codes     = '{4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};
    bad_codes = '{4'h0, 4'h1, 4'h9, 4'hF};

    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
    pat_sel = 4'hB; oos_clr = 1'b1; err_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 oos after reset", oos_flag, 1);
    chk("R1 err after reset", err_flag, 0);
    chk("R2 ready in reset", smp_ready, 1);
    @(negedge clk) rst_n = 1'b1;

    // R3: word ramp from 1, history zero -> every word matches
    for (int k = 1; k <= 15; k++) push(16'(k));
    chk("R3 still oos after 15 hits", oos_flag, 1);
    push(16'd16);
    chk("R3 locked on 16th hit", oos_flag, 0);
    chk("R2 ready streaming", smp_ready, 1);

    // R5: isolated miss while locked
    v = 16'd17;
    push(v); v++;
    push(v ^ 16'h8000); v++;
    chk("R5 err set by miss", err_flag, 1);
    chk("R5 stays locked", oos_flag, 0);
    push(v); v++;
    chk("R5 err sticky", err_flag, 1);
    err_clr = 1'b1; push(v); v++; err_clr = 1'b0;
    chk("R5 err cleared", err_flag, 0);

    // R7 + R4: miss run broken by one hit, then full drop
    for (int k = 0; k < 40; k++) begin push(v ^ 16'h8000); v++; end
    push(v); v++;
    for (int k = 0; k < 63; k++) begin push(v ^ 16'h8000); v++; end
    chk("R7 miss run restarted", oos_flag, 0);
    chk("R4 err during misses", err_flag, 1);
    push(v ^ 16'h8000); v++;
    chk("R4 drop on 64th miss", oos_flag, 1);
    chk("R6 err forced clear", err_flag, 0);

    // R6: misses while out of sync leave err clear
    for (int k = 0; k < 8; k++) push(16'h0000);
    chk("R6 no err when oos", err_flag, 0);
    chk("R6 still oos", oos_flag, 1);

    // R7: hit run broken by a glitch (two misses through self-seeding)
    for (int k = 100; k <= 110; k++) push(16'(k));
    push(16'h5555);
    push(16'd112);
    for (int k = 113; k <= 127; k++) push(16'(k));
    chk("R7 hit run restarted", oos_flag, 1);
    push(16'd128);
    chk("R7 locked after fresh 16", oos_flag, 0);

    // R8: select change forces out of sync
    pat_sel = 4'hA;
    push(16'd129);
    chk("R8 select change drops", oos_flag, 1);

    // R10: sweep all supported selects
    foreach (codes[c]) begin
      pat_sel = codes[c];
      pn_sh = 64'h1234_5678_9ABC_DEF1;
      v  = 16'h0100;
      nb = 4'd3;
      for (int k = 0; k < 32; k++) begin
        case (codes[c])
          4'h4: pn_word(7, 6, w);
          4'h5: pn_word(15, 14, w);
          4'h6: pn_word(23, 18, w);
          4'h7: pn_word(31, 28, w);
          4'hA: begin w = {4{nb}}; nb++; end
          default: begin w = v; v++; end
        endcase
        push(w);
        if (k == 23) chk($sformatf("R10 lock sel %0h", codes[c]), oos_flag, 0);
      end
      chk($sformatf("R10 locked sel %0h", codes[c]), oos_flag, 0);
      chk($sformatf("R10 no err sel %0h", codes[c]), err_flag, 0);
    end

    // R9: unsupported codes never lock
    foreach (bad_codes[c]) begin
      pat_sel = bad_codes[c];
      v = 16'h0200;
      for (int k = 0; k < 24; k++) begin push(v); v++; end
      chk($sformatf("R9 no lock code %0h", bad_codes[c]), oos_flag, 1);
    end

    // R11: sticky out-of-sync flag
    pat_sel = 4'hB;
    oos_clr = 1'b0;
    v = 16'd500;
    for (int k = 0; k < 30; k++) begin push(v); v++; end
    chk("R11 sticky after lock", oos_flag, 1);
    oos_clr = 1'b1; push(v); v++; oos_clr = 1'b0;
    chk("R11 cleared when locked", oos_flag, 0);
    for (int k = 0; k < 5; k++) begin push(v); v++; end
    chk("R11 stays clear", oos_flag, 0);
    for (int k = 0; k < 64; k++) begin push(v ^ 16'h8000); v++; end
    chk("R11 set on drop", oos_flag, 1);
    oos_clr = 1'b1; push(v ^ 16'h8000); v++; oos_clr = 1'b0;
    chk("R11 clear ignored when oos", oos_flag, 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule